// File: doc/BRIEF.md
# Debug-Mode Exception Entry Controller

This block decides what happens when a processor core, already running its debug handler, raises another exception. Each cycle it receives one request line per event type, together with the PC of the instruction that raised it, the PC of the enclosing branch or jump, and a flag that marks the instruction as sitting in a delay slot. A fixed policy marks every event type either as ignored or as a re-entry into the debug handler.

Among the requests that are not ignored, the one with the highest priority wins. It loads the debug return-address register and writes the delay-slot bit and the exception-code field of the debug status register. It clears every debug-cause bit. In the same clock edge it emits a one-cycle redirect pulse toward the handler. Between entries, the surrounding logic can set debug-cause bits through a separate set input. These bits then accumulate until the next entry clears them.

Top module: `dbgx_entry`

## Requirements
- R1: During and straight after a synchronous active-high reset, the redirect pulse is low and the return address, delay-slot bit, cause bits and exception code all read zero.
- R2: Request bit 2 (address-only or store address-plus-value data break) and bit 9 (load address-plus-data data break, lowest priority) are ignored. Alone, they change no output and raise no redirect. Beside a re-entering request, they do not affect which event is taken.
- R3: Among the re-entering requests, the lowest bit index wins. The bit order is: 0 software debug breakpoint, 1 other execution-based exception, 3 data address error, 4 TLB refill, 5 TLB invalid, 6 TLB modified, 7 data cache error, 8 data bus error. Only the winner updates state.
- R4: On entry, the return address takes the current PC when the delay-slot flag is low and the branch PC when it is high. The delay-slot status bit takes the value of the flag.
- R5: On entry, all eight cause bits are cleared, and any cause-set bits presented in that same cycle are discarded.
- R6: When no entry occurs, each cause-set bit ORs into the matching cause bit, and the other fields hold.
- R7: On entry, the 5-bit exception code depends on the winning request: bit 1 gives 10, bit 3 gives 4, bit 4 gives 2, bit 5 gives 3, bit 6 gives 1, bit 7 gives 30, bit 8 gives 7.
- R8: The redirect output is high for exactly the one cycle that follows each edge on which an entry is taken, and it changes together with the register updates.
- R9: A software debug breakpoint (bit 0) is handled like an ordinary break instruction and records code 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req | input | 10 | Per-event exception request lines, bit index as in R3/R2 |
| cur_pc | input | 32 | PC of the instruction raising the request |
| br_pc | input | 32 | PC of the enclosing branch or jump |
| in_dslot | input | 1 | Instruction sits in a delay slot |
| cause_set | input | 8 | Cause bits to set when no entry occurs |
| redirect_o | output | 1 | One-cycle pulse: jump to the debug handler |
| depc_o | output | 32 | Debug return-address register |
| dslot_o | output | 1 | Delay-slot status bit |
| cause_o | output | 8 | Debug-cause bits |
| exc_code_o | output | 5 | Exception-code field |

## Verification
Two pairs of functions can meet in one cycle. An entry can arrive together with a cause-set request, and an ignored data break can arrive together with re-entering events. The bench provokes both pairs with directed vectors: cause bits are set and a re-entry is then fired with a fresh set pattern in the same cycle, and ignored and re-entering bits are combined in one request word. A long run of sparse random request words, random PCs and random delay-slot flags follows. A behavioural model in the bench checks every output on every clock. It expects cleared cause bits and the lower-index winner's code in the first pair, and the re-entering winner in the second.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;

    localparam int NUM_EV  = 10;
    localparam int IDX_W   = $clog2(NUM_EV);
    localparam int CAUSE_W = 8;
    localparam int CODE_W  = 5;

    // request bit index equals priority rank (0 = highest)
    typedef enum logic [IDX_W-1:0] {
        EV_SWBP    = 4'd0,
        EV_EXEC    = 4'd1,
        EV_DBRK_AO = 4'd2,
        EV_DADDR   = 4'd3,
        EV_TLB_RF  = 4'd4,
        EV_TLB_INV = 4'd5,
        EV_TLB_MOD = 4'd6,
        EV_CACHE   = 4'd7,
        EV_BUS     = 4'd8,
        EV_DBRK_LD = 4'd9
    } ev_e;

    // 1 = re-enter handler, 0 = ignore
    localparam logic [NUM_EV-1:0] REENTER_MASK = 10'b01_1111_1011;

    typedef struct packed {
        logic                   hit;
        logic [IDX_W-1:0]       idx;
    } grant_t;

    typedef struct packed {
        logic                   dslot;
        logic [CAUSE_W-1:0]     cause;
        logic [CODE_W-1:0]      code;
    } dstat_t;

    function automatic logic [CODE_W-1:0] ev_code(input logic [IDX_W-1:0] idx);
        logic [CODE_W-1:0] c;
        case (ev_e'(idx))
            EV_SWBP:    c = 5'd9;
            EV_EXEC:    c = 5'd10;
            EV_DADDR:   c = 5'd4;
            EV_TLB_RF:  c = 5'd2;
            EV_TLB_INV: c = 5'd3;
            EV_TLB_MOD: c = 5'd1;
            EV_CACHE:   c = 5'd30;
            EV_BUS:     c = 5'd7;
            default:    c = 5'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dbgx_arbiter.sv
module dbgx_arbiter
    import dbgx_pkg::*;
#(
    parameter int N = NUM_EV,
    parameter logic [N-1:0] MASK = REENTER_MASK,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [N-1:0] elig;
    logic [N-1:0] first;
    logic [N:0]   seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_pri
        assign elig[g]    = req[g] & MASK[g];
        assign first[g]   = elig[g] & ~seen[g];
        assign seen[g+1]  = seen[g] | elig[g];
    end

    assign hit = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/dbgx_status.sv
module dbgx_status
    import dbgx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit,
    input  logic [IDX_W-1:0]    idx,
    input  logic [PC_W-1:0]     pc,
    input  logic [PC_W-1:0]     branch_pc,
    input  logic                in_dslot,
    input  logic [CAUSE_W-1:0]  cause_set,
    output logic [PC_W-1:0]     depc,
    output dstat_t              stat,
    output logic                redirect
);
    always_ff @(posedge clk) begin
        if (rst) begin
            depc     <= '0;
            stat     <= '0;
            redirect <= 1'b0;
        end else if (hit) begin
            depc       <= in_dslot ? branch_pc : pc;
            stat.dslot <= in_dslot;
            stat.cause <= '0;
            stat.code  <= ev_code(idx);
            redirect   <= 1'b1;
        end else begin
            stat.cause <= stat.cause | cause_set;
            redirect   <= 1'b0;
        end
    end

    // every entry must leave a nonzero code behind
    assert_code_valid_R7: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (stat.code != '0));

endmodule

// File: rtl/dbgx_entry.sv
module dbgx_entry
    import dbgx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_EV-1:0]   ev_req,
    input  logic [PC_W-1:0]     cur_pc,
    input  logic [PC_W-1:0]     br_pc,
    input  logic                in_dslot,
    input  logic [CAUSE_W-1:0]  cause_set,
    output logic                redirect_o,
    output logic [PC_W-1:0]     depc_o,
    output logic                dslot_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic [CODE_W-1:0]   exc_code_o
);
    grant_t gnt;
    dstat_t stat;

    dbgx_arbiter #(.N(NUM_EV), .MASK(REENTER_MASK)) u_arb (
        .req (ev_req),
        .hit (gnt.hit),
        .idx (gnt.idx)
    );

    dbgx_status #(.PC_W(PC_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .hit       (gnt.hit),
        .idx       (gnt.idx),
        .pc        (cur_pc),
        .branch_pc (br_pc),
        .in_dslot  (in_dslot),
        .cause_set (cause_set),
        .depc      (depc_o),
        .stat      (stat),
        .redirect  (redirect_o)
    );

    assign dslot_o    = stat.dslot;
    assign cause_o    = stat.cause;
    assign exc_code_o = stat.code;

    // ignored-only requests leave every register untouched
    assert_blocked_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ((ev_req & REENTER_MASK) == '0) |=>
            (!redirect_o && $stable(depc_o) && $stable(dslot_o) && $stable(exc_code_o)));

    assert_depc_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt.hit && in_dslot) |=> (depc_o == $past(br_pc) && dslot_o));

    assert_cause_clear_R5: assert property (@(posedge clk) disable iff (rst)
        gnt.hit |=> (cause_o == '0));

    assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && !$past(gnt.hit)) |-> 1'b0);

    assert_swbp_code_R9: assert property (@(posedge clk) disable iff (rst)
        ev_req[0] |=> (exc_code_o == 5'd9));

endmodule

// File: tb/test_dbgx_entry.sv
module test_dbgx_entry;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  ev_req = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] br_pc = '0;
    logic        in_dslot = 1'b0;
    logic [7:0]  cause_set = '0;
    logic        redirect_o;
    logic [31:0] depc_o;
    logic        dslot_o;
    logic [7:0]  cause_o;
    logic [4:0]  exc_code_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // reference state
    logic        m_red;
    logic [31:0] m_depc;
    logic        m_dslot;
    logic [7:0]  m_cause;
    logic [4:0]  m_code;

    always #5 clk = ~clk;

    dbgx_entry i_dbgx_entry (
        .clk(clk), .rst(rst), .ev_req(ev_req), .cur_pc(cur_pc), .br_pc(br_pc),
        .in_dslot(in_dslot), .cause_set(cause_set), .redirect_o(redirect_o),
        .depc_o(depc_o), .dslot_o(dslot_o), .cause_o(cause_o), .exc_code_o(exc_code_o)
    );

    function automatic int code_of(int b);
        case (b)
            0: return 9;    // R9
            1: return 10;
            3: return 4;
            4: return 2;
            5: return 3;
            6: return 1;
            7: return 30;
            8: return 7;
            default: return -1;  // ignored (R2)
        endcase
    endfunction

    // advance the model by one clock using the inputs seen at that edge
    task automatic model_step();
        int win = -1;
        if (rst) begin
            m_red = 0; m_depc = 0; m_dslot = 0; m_cause = 0; m_code = 0;
            return;
        end
        for (int b = 0; b < 10; b++)
            if (win < 0 && ev_req[b] && code_of(b) >= 0) win = b;   // R3
        if (win >= 0) begin
            m_red   = 1;
            m_depc  = in_dslot ? br_pc : cur_pc;                      // R4
            m_dslot = in_dslot;
            m_cause = 0;                                              // R5
            m_code  = 5'(code_of(win));                               // R7
        end else begin
            m_red   = 0;
            m_cause = m_cause | cause_set;                            // R6
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag == "" ? "R8" : tag, "redirect", 32'(redirect_o), 32'(m_red));
        chk(tag == "" ? "R4" : tag, "depc", depc_o, m_depc);
        chk(tag == "" ? "R4" : tag, "dslot", 32'(dslot_o), 32'(m_dslot));
        chk(tag == "" ? "R5 or R6" : tag, "cause", 32'(cause_o), 32'(m_cause));
        chk(tag == "" ? "R7" : tag, "code", 32'(exc_code_o), 32'(m_code));
    endtask

    // one cycle: inputs already applied; wait edge, step model, compare at negedge
    task automatic cyc(string tag, logic [9:0] req, logic [31:0] pc, logic [31:0] bpc,
                       logic ds, logic [7:0] cs);
        ev_req = req; cur_pc = pc; br_pc = bpc; in_dslot = ds; cause_set = cs;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc("R1", '0, 32'h0, 32'h0, 0, 8'h00);
        rst = 1'b0;
        cyc("R1", '0, 32'h0, 32'h0, 0, 8'h00);

        // R6: cause bits accumulate
        cyc("R6", '0, 32'h100, 32'h0, 0, 8'h05);
        cyc("R6", '0, 32'h104, 32'h0, 0, 8'hA0);
        // R2: ignored events alone
        cyc("R2", 10'h004, 32'h200, 32'h1FC, 1, 8'h00);
        cyc("R2", 10'h200, 32'h204, 32'h1FC, 1, 8'h00);
        cyc("R2", 10'h204, 32'h208, 32'h1FC, 0, 8'h00);
        // R9: software breakpoint, with R5 cause-set collision
        cyc("R9", 10'h001, 32'h300, 32'h2FC, 0, 8'hFF);
        cyc("R8", '0, 32'h304, 32'h0, 0, 8'h00);
        // R7: each re-entering event alone, R4 with delay slot
        for (int b = 1; b < 9; b++) begin
            if (b != 2) begin
                cyc("R7", 10'(1 << b), 32'h1000 + 32'(b*4), 32'h0F00 + 32'(b*4), b[0], 8'h00);
                cyc("R8", '0, 32'h0, 32'h0, 0, 8'h11);
            end
        end
        // R3: simultaneous requests, lowest index wins; R2 ignored bits alongside
        cyc("R3", 10'h1F8, 32'h400, 32'h3FC, 0, 8'h00);
        cyc("R3", 10'h384, 32'h404, 32'h3FC, 1, 8'h00);
        cyc("R3", 10'h206, 32'h408, 32'h3FC, 0, 8'h00);
        // back-to-back entries keep redirect high (R8)
        cyc("R8", 10'h100, 32'h500, 32'h4FC, 0, 8'h00);
        cyc("R8", 10'h040, 32'h504, 32'h4FC, 1, 8'h00);
        cyc("R8", '0, 32'h508, 32'h0, 0, 8'h00);

        // random phase, every output compared every clock
        for (int n = 0; n < 3000; n++) begin
            cyc("", 10'($urandom & $urandom & $urandom), $urandom, $urandom,
                1'($urandom), 8'($urandom & $urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule